// File: doc/BRIEF.md
# Masked Lock-Step SIMD Processing Array

This block is a small array of identical processing elements (PEs). Each PE owns a private register file that holds its own data stream. A single instruction stream feeds the array. Each instruction word is broadcast to every PE in the same step, and every selected PE applies it to its own operands. The instruction set is deliberately small: add, unsigned compare, register move and no-operation.

Each instruction word carries an activity mask with one bit per PE. A PE whose bit is clear does not execute the instruction, and all of its registers keep their values for that step. A global step barrier keeps the array in lock-step. An instruction is accepted on a valid/ready handshake. Each PE then raises a done flag once its part of the step is over, whether it executed the instruction or sat idle. Ready stays low until every flag is set, so the next instruction cannot start while any PE is still inside the current step.

Before a run, a host preloads operands through a load port that writes one register of one PE per cycle. Results are inspected through a combinational read-back port.

Top module: `simd_lockstep_array`

## Requirements
- R1: After reset every register of every PE reads 0 and `instr_ready` is 1.
- R2: While `instr_ready` is 1, `load_en` writes `load_data` into register `load_reg` of PE `load_pe` at the clock edge. From then on, `rd_data` returns that value when `rd_pe`/`rd_reg` select it.
- R3: An instruction is taken at an edge where `instr_valid` and `instr_ready` are both 1. `instr_ready` is then 0 for exactly one cycle and returns to 1 in the cycle after.
- R4: Instruction word layout, from bit 0 upward: opcode in 2 bits (0 = NOP, 1 = ADD, 2 = CMP, 3 = MOV), first source index, second source index, destination index (each `$clog2(NUM_REGS)` bits), then an `NUM_PE`-bit mask whose bit i selects PE i.
- R5: ADD writes (first source + second source) modulo 2^DATA_W to the destination.
- R6: CMP writes 1 to the destination when the first source is less than the second as unsigned numbers, and 0 otherwise (equal operands give 0).
- R7: MOV copies the first source to the destination.
- R8: NOP changes no register in any PE, whatever its mask.
- R9: A PE whose mask bit is 0 keeps every one of its registers unchanged through the step.
- R10: An instruction with an all-zero mask still takes a full step (`instr_ready` low for one cycle) and changes no register.
- R11: A load request made while `instr_ready` is 0 is ignored.
- R12: Results are written at the edge that ends the step, so they are readable once `instr_ready` is back at 1. Operands are the values held before the step, even when the destination is also a source.
- R13: All selected PEs execute the same instruction in the same step, each on its own register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is presented |
| instr_ready | output | 1 | All PEs have finished the previous step |
| instr_word | input | 2+3*$clog2(NUM_REGS)+NUM_PE | Broadcast instruction (layout in R4) |
| load_en | input | 1 | Setup write request |
| load_pe | input | $clog2(NUM_PE) | PE targeted by the setup write |
| load_reg | input | $clog2(NUM_REGS) | Register targeted by the setup write |
| load_data | input | DATA_W | Setup write data |
| rd_pe | input | $clog2(NUM_PE) | PE selected for read-back |
| rd_reg | input | $clog2(NUM_REGS) | Register selected for read-back |
| rd_data | output | DATA_W | Contents of the selected register |

## Verification
Most corruptions of internal state appear on `rd_data` as soon as the affected register is selected, one step after the faulty instruction. Examples are a wrong operand select, a masked PE that writes anyway, or a load that slips in while a step is still running. The bench therefore scans every register of every PE after each step and compares it with a model, so a fault is reported at the first instruction that exposes it. A broken barrier shows up immediately on `instr_ready`: the ready level is checked both in the cycle after acceptance and in the cycle that follows.

// File: rtl/simd_lockstep_array.sv
module simd_lockstep_array #(
  parameter int NUM_PE   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int RIW     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int PIW     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int INSTR_W = 2 + 3*RIW + NUM_PE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               load_en,
  input  logic [PIW-1:0]     load_pe,
  input  logic [RIW-1:0]     load_reg,
  input  logic [DATA_W-1:0]  load_data,
  input  logic [PIW-1:0]     rd_pe,
  input  logic [RIW-1:0]     rd_reg,
  output logic [DATA_W-1:0]  rd_data
);
  localparam logic [1:0] OP_NOP = 2'd0;
  localparam logic [1:0] OP_ADD = 2'd1;
  localparam logic [1:0] OP_CMP = 2'd2;
  localparam logic [1:0] OP_MOV = 2'd3;

  logic [INSTR_W-1:0] cur_q;
  logic [NUM_PE-1:0]  done;
  logic [DATA_W-1:0]  pe_rd [NUM_PE];

  wire               accept = instr_valid && instr_ready;
  wire [1:0]         op     = cur_q[1:0];
  wire [RIW-1:0]     src_a  = cur_q[2 +: RIW];
  wire [RIW-1:0]     src_b  = cur_q[2+RIW +: RIW];
  wire [RIW-1:0]     dst    = cur_q[2+2*RIW +: RIW];
  wire [NUM_PE-1:0]  mask   = cur_q[2+3*RIW +: NUM_PE];

  assign instr_ready = &done;
  assign rd_data     = pe_rd[rd_pe];

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_q <= '0;
    else if (accept) cur_q <= instr_word;
  end

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    logic [DATA_W-1:0] rf [NUM_REGS];
    logic [DATA_W-1:0] res;
    logic              done_q;

    wire [DATA_W-1:0] opa = rf[src_a];
    wire [DATA_W-1:0] opb = rf[src_b];
    wire wr = !done_q && mask[g] && (op != OP_NOP);
    wire ld = load_en && instr_ready && (load_pe == PIW'(g));

    always_comb begin
      case (op)
        OP_ADD:  res = opa + opb;
        OP_CMP:  res = (opa < opb) ? DATA_W'(1) : '0;
        OP_MOV:  res = opa;
        default: res = opa;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q <= 1'b1;
        for (int i = 0; i < NUM_REGS; i++) rf[i] <= '0;
      end else begin
        if (accept)       done_q <= 1'b0;
        else if (!done_q) done_q <= 1'b1;
        if (wr)           rf[dst]      <= res;
        else if (ld)      rf[load_reg] <= load_data;
      end
    end

    assign done[g]  = done_q;
    assign pe_rd[g] = rf[rd_reg];
  end
endmodule

// File: rtl/simd_lockstep_array_chk.sv
module simd_lockstep_array_chk #(
  parameter int PIW    = 2,
  parameter int RIW    = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic              load_en,
  input logic [PIW-1:0]    rd_pe,
  input logic [RIW-1:0]    rd_reg,
  input logic [DATA_W-1:0] rd_data
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready) |=> !instr_ready); // R3

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |=> instr_ready); // R3

  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(instr_ready && !load_en && !instr_valid) && $stable(rd_pe) && $stable(rd_reg))
      |-> $stable(rd_data)); // R8

  AST_READ_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({instr_ready, rd_data})); // R1
endmodule

bind simd_lockstep_array simd_lockstep_array_chk #(
  .PIW(PIW), .RIW(RIW), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .load_en(load_en), .rd_pe(rd_pe), .rd_reg(rd_reg), .rd_data(rd_data)
);

// File: tb/test_simd_lockstep_array.sv
module test_simd_lockstep_array;
  localparam int NUM_PE = 4, DATA_W = 8, NUM_REGS = 4;
  localparam int RIW = $clog2(NUM_REGS), PIW = $clog2(NUM_PE);
  localparam int IW = 2 + 3*RIW + NUM_PE;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, instr_ready;
  logic [IW-1:0] instr_word = '0;
  logic load_en = 0;
  logic [PIW-1:0] load_pe = '0, rd_pe = '0;
  logic [RIW-1:0] load_reg = '0, rd_reg = '0;
  logic [DATA_W-1:0] load_data = '0, rd_data;

  int checks = 0, failures = 0;
  logic [DATA_W-1:0] m [NUM_PE][NUM_REGS];

  always #10 clk = ~clk;

  simd_lockstep_array #(.NUM_PE(NUM_PE), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_simd_lockstep_array (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .load_en(load_en), .load_pe(load_pe), .load_reg(load_reg),
    .load_data(load_data), .rd_pe(rd_pe), .rd_reg(rd_reg), .rd_data(rd_data));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(int op, int sa, int sb, int d, int mask);
    return {NUM_PE'(mask), RIW'(d), RIW'(sb), RIW'(sa), 2'(op)};
  endfunction

  function automatic string req_of(int op, bit sel);
    if (!sel) return "R9 masked PE";
    case (op)
      1: return "R5 ADD";
      2: return "R6 CMP";
      3: return "R7 MOV";
      default: return "R8 NOP";
    endcase
  endfunction

  task automatic scan(string tag);
    for (int p = 0; p < NUM_PE; p++)
      for (int r = 0; r < NUM_REGS; r++) begin
        @(negedge clk); rd_pe = PIW'(p); rd_reg = RIW'(r); #1;
        check(tag, int'(rd_data), int'(m[p][r]));
      end
  endtask

  task automatic load(int p, int r, int d);
    @(negedge clk);
    load_en = 1; load_pe = PIW'(p); load_reg = RIW'(r); load_data = DATA_W'(d);
    @(negedge clk); load_en = 0;
    m[p][r] = DATA_W'(d);
  endtask

  task automatic model_step(logic [IW-1:0] w);
    logic [DATA_W-1:0] a, b, res;
    int op = int'(w[1:0]);
    int sa = int'(w[2 +: RIW]), sb = int'(w[2+RIW +: RIW]), d = int'(w[2+2*RIW +: RIW]);
    for (int p = 0; p < NUM_PE; p++) begin
      if (w[2+3*RIW+p] && op != 0) begin
        a = m[p][sa]; b = m[p][sb];
        case (op)
          1: res = a + b;
          2: res = (a < b) ? DATA_W'(1) : '0;
          default: res = a;
        endcase
        m[p][d] = res;
      end
    end
  endtask

  task automatic issue(logic [IW-1:0] w, bit busy_load, string tag);
    @(negedge clk); instr_word = w; instr_valid = 1; #1;
    check("R3 ready before accept", int'(instr_ready), 1);
    @(negedge clk); instr_valid = 0;
    check({tag, " R3 ready low during step"}, int'(instr_ready), 0);
    model_step(w);
    if (busy_load) begin
      load_en = 1; load_pe = PIW'($urandom_range(NUM_PE-1));
      load_reg = RIW'($urandom_range(NUM_REGS-1)); load_data = DATA_W'($urandom);
    end
    @(negedge clk); load_en = 0;
    check({tag, " R3 ready back"}, int'(instr_ready), 1);
    scan(tag);
  endtask

  initial begin
    #(20*200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < NUM_PE; p++)
      for (int r = 0; r < NUM_REGS; r++) m[p][r] = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(instr_ready), 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", int'(instr_ready), 1);
    scan("R1 reset value");

    for (int p = 0; p < NUM_PE; p++)
      for (int r = 0; r < NUM_REGS; r++) load(p, r, (p*37 + r*11 + 5) & 8'hff);
    scan("R2 load");

    load(0, 0, 255); load(0, 1, 1);
    load(1, 0, 7);   load(1, 1, 7);
    load(2, 0, 3);   load(2, 1, 200);
    issue(mk(1, 0, 1, 2, 4'b0001), 0, "R5 ADD wrap");
    issue(mk(2, 0, 1, 3, 4'b0110), 0, "R6 CMP equal/less R13");
    issue(mk(3, 1, 0, 1, 4'b1111), 0, "R7 MOV R13");
    issue(mk(1, 0, 0, 0, 4'b1010), 0, "R12 dst is source");
    issue(mk(1, 0, 1, 2, 4'b0000), 1, "R10 empty mask R11");
    issue(mk(0, 0, 1, 2, 4'b1111), 0, "R8 NOP");
    issue(mk(1, 2, 3, 0, 4'b0101), 1, "R9 partial mask R11");

    for (int k = 0; k < 150; k++) begin
      logic [IW-1:0] w = mk($urandom_range(3), $urandom_range(NUM_REGS-1),
                            $urandom_range(NUM_REGS-1), $urandom_range(NUM_REGS-1),
                            $urandom_range((1<<NUM_PE)-1));
      issue(w, bit'($urandom_range(1)), {req_of(int'(w[1:0]), |w[IW-1 -: NUM_PE]), " R4 random"});
      if ((k % 10) == 0)
        load($urandom_range(NUM_PE-1), $urandom_range(NUM_REGS-1), $urandom_range(255));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule